// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits at the front of a 2D graphics engine. It takes in a stream of 32-bit command words and cuts it into whole command packets. The top byte of the first word of each packet is the opcode. The opcode sets how many argument words follow, or, for multi-segment lines, which kind of terminator word closes the packet. Each packet is collected in full in a local buffer. It is then played out downstream one word per transfer, with first and last markers and a three-bit category tag. While a packet is being played out, the input side stalls. A downstream unit therefore never sees part of a packet.

Environment-setting opcodes (0xE0 to 0xE7) are never passed downstream. They write the whole word into one of eight shadow registers. A small status field is refreshed from two of those registers at the end of every packet. Image-transfer opcodes are framed only as their three-word header and tagged as a read or a write. The pixel payload that follows them is handled by a separate transfer engine and does not enter this block.

Top module: `pfr_framer`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and status is 0. Shadow register i (bits 32*i+31 down to 32*i of shadow_regs) holds (0xE0+i) shifted left by 24.
- R2: For opcodes other than the line strips, the packet length in words is 1 plus the argument count. The counts are: 0x02 takes 2; 0x20-0x23 take 3, 0x24-0x27 take 6, 0x28-0x2B take 4, 0x2C-0x2F take 8, 0x30-0x33 take 5, 0x34-0x37 take 8, 0x38-0x3B take 7, 0x3C-0x3F take 11; 0x40-0x47 take 2, 0x50-0x57 take 3; 0x60-0x63 take 2, 0x64-0x67 take 3, 0x68-0x6B take 1, 0x6C-0x6F take 0, 0x70-0x73 take 1, 0x74-0x77 take 2, 0x78-0x7B take 1, 0x7C-0x7F take 2; 0x80-0x9F take 3; 0xA0-0xDF take 2; every other opcode takes 0.
- R3: out_tag carries the category for the whole packet. The codes are: 1 for fill (0x02), 2 for interrupt request (0x1F), 3 for drawing (0x20-0x7F except the line strips), 4 for line strip, 5 for rectangle copy (0x80-0x9F), 6 for image write, 7 for image read, and 0 for any other opcode that is emitted.
- R4: Opcodes 0xA0-0xDF form a 3-word packet. The tag is 7 when opcode bits 7:5 are 110, and 6 otherwise.
- R5: For flat line strips (0x48-0x4F), the packet ends at the first word with index 3 or higher (word 0 is the opcode word) for which (word AND 0xF000F000) equals 0x50005000. That word is included in the packet. A matching word at index 1 or 2 does not end the packet.
- R6: For shaded line strips (0x58-0x5F), only even word indices from 4 upward are tested against the same terminator pattern. A match at an odd index does not end the packet.
- R7: A line strip with no terminator is closed at 256 words. out_trunc is 1 for every word of that packet and 0 for every word of all other packets.
- R8: Opcodes 0xE0-0xE7 write the whole word into shadow register (opcode AND 7). They produce no downstream output.
- R9: status changes only in the cycle after the last word of a packet is accepted. It then equals {shadow6[1:0], shadow1[10:0]}.
- R10: in_ready is 0 whenever out_valid is 1. out_valid rises only after the whole packet has been accepted. Under back-pressure the outputs are held stable. After the last word is taken, out_valid drops and in_ready returns.
- R11: Packet words are emitted in arrival order. out_first marks word 0 and out_last marks the final word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | 32 | Command word |
| out_valid | output | 1 | Packet word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Packet word |
| out_tag | output | 3 | Packet category code |
| out_first | output | 1 | First word of packet |
| out_last | output | 1 | Final word of packet |
| out_trunc | output | 1 | Line strip closed at the length cap |
| status | output | 13 | Mirror of shadow register bits |
| shadow_regs | output | 256 | Eight shadow registers, register i at bits 32*i+31:32*i |

## Verification
The assertions check every cycle that input and output are mutually exclusive, that outputs hold under back-pressure, that status moves only after an accepted word, that environment words never reach the output, that image-transfer headers carry the right read or write tag, and that the truncation flag appears only on line strips. Packet lengths from the opcode table, the terminator rules with decoy patterns at untested indices, the 256-word cap, the word order and the shadow contents can only be shown by the bench's scenarios against its own model.

// File: rtl/pfr_pkg.sv
// Package: shared category codes and opcode decoding for the packet framer.
// Assumes the opcode sits in bits 31:24 of the first word of a packet.
package pfr_pkg;

    typedef enum logic [2:0] {
        TAG_MISC = 3'd0,
        TAG_FILL = 3'd1,
        TAG_IRQ  = 3'd2,
        TAG_DRAW = 3'd3,
        TAG_POLY = 3'd4,
        TAG_COPY = 3'd5,
        TAG_XWR  = 3'd6,
        TAG_XRD  = 3'd7
    } pkt_tag_e;

    // Number of argument words that follow the opcode word
    function automatic logic [3:0] arg_words(input logic [7:0] op);
        logic [3:0] n;
        n = 4'd0;
        if (op == 8'h02) begin
            n = 4'd2;
        end else if (op[7:5] == 3'b001) begin
            case (op[4:2])
                3'd0: n = 4'd3;
                3'd1: n = 4'd6;
                3'd2: n = 4'd4;
                3'd3: n = 4'd8;
                3'd4: n = 4'd5;
                3'd5: n = 4'd8;
                3'd6: n = 4'd7;
                default: n = 4'd11;
            endcase
        end else if (op[7:5] == 3'b010) begin
            case (op[4:3])
                2'd0: n = 4'd2;
                2'd1: n = 4'd3;
                2'd2: n = 4'd3;
                default: n = 4'd4;
            endcase
        end else if (op[7:5] == 3'b011) begin
            case (op[4:2])
                3'd0: n = 4'd2;
                3'd1: n = 4'd3;
                3'd2: n = 4'd1;
                3'd3: n = 4'd0;
                3'd4: n = 4'd1;
                3'd5: n = 4'd2;
                3'd6: n = 4'd1;
                default: n = 4'd2;
            endcase
        end else if (op[7:5] == 3'b100) begin
            n = 4'd3;
        end else if (op[7:5] == 3'b101 || op[7:5] == 3'b110) begin
            n = 4'd2;
        end
        return n;
    endfunction

    // Line strip opcodes: 0x48-0x4F (flat) and 0x58-0x5F (shaded)
    function automatic logic is_strip(input logic [7:0] op);
        return (op[7:5] == 3'b010) && op[3];
    endfunction

    // Environment setting opcodes 0xE0-0xE7
    function automatic logic is_env(input logic [7:0] op);
        return op[7:3] == 5'b11100;
    endfunction

    // Category of an emitted packet
    function automatic pkt_tag_e classify(input logic [7:0] op);
        pkt_tag_e t;
        t = TAG_MISC;
        if (op == 8'h02)                          t = TAG_FILL;
        else if (op == 8'h1F)                     t = TAG_IRQ;
        else if (op[7:5] == 3'b001 || op[7:5] == 3'b011) t = TAG_DRAW;
        else if (op[7:5] == 3'b010)               t = is_strip(op) ? TAG_POLY : TAG_DRAW;
        else if (op[7:5] == 3'b100)               t = TAG_COPY;
        else if (op[7:5] == 3'b110)               t = TAG_XRD;
        else if (op[7:5] == 3'b101)               t = TAG_XWR;
        return t;
    endfunction

endpackage

// File: rtl/pfr_collect.sv
// Collector: accepts input words, decides where each packet ends and
// reports the completed packet to the emitter. Assumes MAX_WORDS >= 16 and
// a power of two; busy from the emitter stalls the input.
module pfr_collect
    import pfr_pkg::*;
#(
    parameter int MAX_WORDS = 256,
    localparam int IW = $clog2(MAX_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   in_data,
    input  logic          busy,
    output logic          wr_en,
    output logic [IW-1:0] wr_addr,
    output logic          pkt_end,
    output logic          pkt_emit,
    output logic [IW-1:0] pkt_last,
    output pkt_tag_e      pkt_tag,
    output logic          pkt_trunc,
    output logic          env_wr,
    output logic [2:0]    env_idx
);

    logic [IW-1:0] idx;
    logic [7:0]    op_q;
    logic [7:0]    cur_op;
    logic          accept;
    logic          first;
    logic          strip;
    logic          term_hit;
    logic          at_cap;
    logic          fixed_end;
    logic          ends;

    // Decode the current word against the opcode of the packet in progress
    always_comb begin
        accept    = in_valid && in_ready;
        first     = (idx == '0);
        cur_op    = first ? in_data[31:24] : op_q;
        strip     = is_strip(cur_op);
        term_hit  = ((in_data & 32'hF000_F000) == 32'h5000_5000) &&
                    (cur_op[4] ? (idx >= IW'(4) && !idx[0]) : (idx >= IW'(3)));
        at_cap    = (idx == IW'(MAX_WORDS - 1));
        fixed_end = (idx == IW'(arg_words(cur_op)));
        ends      = strip ? (term_hit || at_cap) : fixed_end;
    end

    // Outputs toward the buffer, emitter and shadow bank
    always_comb begin
        in_ready  = !busy;
        wr_en     = accept;
        wr_addr   = idx;
        pkt_end   = accept && ends;
        pkt_emit  = accept && ends && !is_env(cur_op);
        pkt_last  = idx;
        pkt_tag   = classify(cur_op);
        pkt_trunc = strip && at_cap && !term_hit;
        env_wr    = accept && first && is_env(cur_op);
        env_idx   = cur_op[2:0];
    end

    // Word index within the packet and latched opcode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            op_q <= 8'h00;
        end else if (accept) begin
            if (first) op_q <= in_data[31:24];
            idx <= ends ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/pfr_wordbuf.sv
// Word buffer: holds one packet; single write port, asynchronous read port.
// Assumes writer and reader never use it at the same time.
module pfr_wordbuf #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem [DEPTH];

    // Store accepted words
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Read for the emitter
    always_comb rd_data = mem[rd_addr];

endmodule

// File: rtl/pfr_emit.sv
// Emitter: plays out a completed packet word by word under out_ready.
// Assumes start only arrives while not busy.
module pfr_emit
    import pfr_pkg::*;
#(
    parameter int MAX_WORDS = 256,
    localparam int IW = $clog2(MAX_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] start_last,
    input  pkt_tag_e      start_tag,
    input  logic          start_trunc,
    output logic          busy,
    output logic [IW-1:0] rd_addr,
    input  logic [31:0]   rd_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [31:0]   out_data,
    output logic [2:0]    out_tag,
    output logic          out_first,
    output logic          out_last,
    output logic          out_trunc
);

    logic [IW-1:0] rd;
    logic [IW-1:0] last_q;
    pkt_tag_e      tag_q;
    logic          trunc_q;

    // Sequence through the buffered packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rd      <= '0;
            last_q  <= '0;
            tag_q   <= TAG_MISC;
            trunc_q <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            rd      <= '0;
            last_q  <= start_last;
            tag_q   <= start_tag;
            trunc_q <= start_trunc;
        end else if (busy && out_ready) begin
            if (rd == last_q) begin
                busy <= 1'b0;
                rd   <= '0;
            end else begin
                rd <= rd + 1'b1;
            end
        end
    end

    // Present the current word with its markers
    always_comb begin
        rd_addr   = rd;
        out_valid = busy;
        out_data  = rd_data;
        out_tag   = tag_q;
        out_first = busy && (rd == '0);
        out_last  = busy && (rd == last_q);
        out_trunc = busy && trunc_q;
    end

endmodule

// File: rtl/pfr_shadow.sv
// Shadow bank: eight environment registers with reset values
// (0xE0+i)<<24 and a status field refreshed at every packet end.
module pfr_shadow #(
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              pkt_end,
    output logic [NREG*32-1:0] regs_flat,
    output logic [12:0]       status
);

    logic [31:0] nxt [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [31:0] r;

        // Value this register holds after the current cycle
        always_comb nxt[i] = (wr && wr_idx == 3'(i)) ? wr_data : r;

        // Register with its own reset value
        always_ff @(posedge clk) begin
            if (!rst_n) r <= {8'(8'hE0 + i), 24'h0};
            else        r <= nxt[i];
        end

        assign regs_flat[i*32 +: 32] = r;
    end

    // Refresh the status mirror when a packet completes
    always_ff @(posedge clk) begin
        if (!rst_n)       status <= 13'h0;
        else if (pkt_end) status <= {nxt[6][1:0], nxt[1][10:0]};
    end

endmodule

// File: rtl/pfr_framer.sv
// Top: command packet framer. Collects a whole packet, then emits it with
// category tag; environment opcodes go to the shadow bank instead.
module pfr_framer
    import pfr_pkg::*;
#(
    parameter int MAX_WORDS = 256,
    localparam int IW = $clog2(MAX_WORDS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [31:0]  in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [31:0]  out_data,
    output logic [2:0]   out_tag,
    output logic         out_first,
    output logic         out_last,
    output logic         out_trunc,
    output logic [12:0]  status,
    output logic [255:0] shadow_regs
);

    logic          busy;
    logic          wr_en;
    logic [IW-1:0] wr_addr;
    logic [IW-1:0] rd_addr;
    logic [31:0]   rd_data;
    logic          pkt_end;
    logic          pkt_emit;
    logic [IW-1:0] pkt_last;
    pkt_tag_e      pkt_tag;
    logic          pkt_trunc;
    logic          env_wr;
    logic [2:0]    env_idx;

    pfr_collect #(.MAX_WORDS(MAX_WORDS)) u_collect (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .pkt_end(pkt_end), .pkt_emit(pkt_emit), .pkt_last(pkt_last),
        .pkt_tag(pkt_tag), .pkt_trunc(pkt_trunc),
        .env_wr(env_wr), .env_idx(env_idx)
    );

    pfr_wordbuf #(.DEPTH(MAX_WORDS), .W(32)) u_buf (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    pfr_emit #(.MAX_WORDS(MAX_WORDS)) u_emit (
        .clk(clk), .rst_n(rst_n),
        .start(pkt_emit), .start_last(pkt_last), .start_tag(pkt_tag),
        .start_trunc(pkt_trunc), .busy(busy),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_tag(out_tag), .out_first(out_first), .out_last(out_last),
        .out_trunc(out_trunc)
    );

    pfr_shadow #(.NREG(8)) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .wr(env_wr), .wr_idx(env_idx), .wr_data(in_data),
        .pkt_end(pkt_end), .regs_flat(shadow_regs), .status(status)
    );

endmodule

// File: rtl/pfr_framer_chk.sv
// Checker: port-level protocol properties of the framer, bound to the top.
module pfr_framer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic [2:0]  out_tag,
    input logic        out_first,
    input logic        out_last,
    input logic        out_trunc,
    input logic [12:0] status
);

    a_r10_stall_while_emit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r10_hold_on_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag)
                                    && $stable(out_first) && $stable(out_last));

    a_r10_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid && in_ready);

    a_r11_rise_on_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_first);

    a_r9_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(status));

    a_r8_env_not_emitted: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_first |-> out_data[31:27] != 5'b11100);

    a_r4_xfer_direction: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_first && (out_data[31:29] == 3'b101 || out_data[31:29] == 3'b110)
        |-> out_tag == ((out_data[31:29] == 3'b110) ? 3'd7 : 3'd6));

    a_r7_trunc_only_strip: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_trunc |-> out_tag == 3'd4);

endmodule

bind pfr_framer pfr_framer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_tag(out_tag), .out_first(out_first), .out_last(out_last),
    .out_trunc(out_trunc), .status(status)
);

// File: tb/pfr_framer_test.sv
module pfr_framer_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [31:0]  out_data;
    logic [2:0]   out_tag;
    logic         out_first, out_last, out_trunc;
    logic [12:0]  status;
    logic [255:0] shadow_regs;

    int total = 0;
    int bad = 0;
    bit bp_en = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] d;
        logic [2:0]  t;
        logic        f, l, tr;
        string       rq;
    } exp_t;

    exp_t        q[$];
    logic [31:0] pk[$];
    logic [31:0] sh[8];

    pfr_framer uut (.*);

    always #2 clk = ~clk;

    // Random back-pressure, driven just after the edge
    always @(posedge clk) begin
        #1 out_ready <= bp_en ? (($urandom % 4) != 0) : 1'b1;
    end

    // Output monitor: compares accepted words with the model queue
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            total++;
            if (in_ready) begin
                bad++;
                $display("FAIL R10 in_ready=%0b expected 0 while emitting", in_ready);
            end
            if (out_ready) begin
                total++;
                if (q.size() == 0) begin
                    bad++;
                    $display("FAIL R11 unexpected word %h expected none", out_data);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (out_data !== e.d || out_tag !== e.t || out_first !== e.f ||
                        out_last !== e.l || out_trunc !== e.tr) begin
                        bad++;
                        $display("FAIL %s got d=%h t=%0d f=%0b l=%0b tr=%0b expected d=%h t=%0d f=%0b l=%0b tr=%0b",
                                 e.rq, out_data, out_tag, out_first, out_last, out_trunc,
                                 e.d, e.t, e.f, e.l, e.tr);
                    end
                end
            end
        end
    end

    // Argument count table of R2
    function automatic int exp_args(input logic [7:0] op);
        if (op == 8'h02) return 2;
        if (op >= 8'h20 && op <= 8'h23) return 3;
        if (op >= 8'h24 && op <= 8'h27) return 6;
        if (op >= 8'h28 && op <= 8'h2B) return 4;
        if (op >= 8'h2C && op <= 8'h2F) return 8;
        if (op >= 8'h30 && op <= 8'h33) return 5;
        if (op >= 8'h34 && op <= 8'h37) return 8;
        if (op >= 8'h38 && op <= 8'h3B) return 7;
        if (op >= 8'h3C && op <= 8'h3F) return 11;
        if (op >= 8'h40 && op <= 8'h47) return 2;
        if (op >= 8'h50 && op <= 8'h57) return 3;
        if (op >= 8'h60 && op <= 8'h63) return 2;
        if (op >= 8'h64 && op <= 8'h67) return 3;
        if (op >= 8'h68 && op <= 8'h6B) return 1;
        if (op >= 8'h70 && op <= 8'h73) return 1;
        if (op >= 8'h74 && op <= 8'h77) return 2;
        if (op >= 8'h78 && op <= 8'h7B) return 1;
        if (op >= 8'h7C && op <= 8'h7F) return 2;
        if (op >= 8'h80 && op <= 8'h9F) return 3;
        if (op >= 8'hA0 && op <= 8'hDF) return 2;
        return 0;
    endfunction

    function automatic bit is_line(input logic [7:0] op);
        return (op >= 8'h48 && op <= 8'h4F) || (op >= 8'h58 && op <= 8'h5F);
    endfunction

    // Category codes of R3 and R4
    function automatic logic [2:0] exp_tag(input logic [7:0] op);
        if (op == 8'h02) return 3'd1;
        if (op == 8'h1F) return 3'd2;
        if (is_line(op)) return 3'd4;
        if (op >= 8'h20 && op <= 8'h7F) return 3'd3;
        if (op >= 8'h80 && op <= 8'h9F) return 3'd5;
        if (op >= 8'hC0 && op <= 8'hDF) return 3'd7;
        if (op >= 8'hA0 && op <= 8'hBF) return 3'd6;
        return 3'd0;
    endfunction

    task automatic send_word(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        forever begin
            @(negedge clk);
            if (in_ready) begin
                @(posedge clk);
                #1;
                break;
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic check_status(input string rq);
        logic [12:0] e;
        e = {sh[6][1:0], sh[1][10:0]};
        total++;
        if (status !== e) begin
            bad++;
            $display("FAIL %s status=%h expected %h", rq, status, e);
        end
    endtask

    // Push the model view of pk[] and send it
    task automatic send_pk(input logic [2:0] tag, input bit trunc, input string rq);
        logic [7:0] op;
        op = pk[0][31:24];
        if (op >= 8'hE0 && op <= 8'hE7) begin
            sh[op[2:0]] = pk[0];
        end else begin
            for (int i = 0; i < pk.size(); i++) begin
                exp_t e;
                e.d = pk[i]; e.t = tag; e.f = (i == 0); e.l = (i == pk.size() - 1);
                e.tr = trunc; e.rq = rq;
                q.push_back(e);
            end
        end
        for (int i = 0; i < pk.size(); i++) send_word(pk[i]);
        check_status("R9");
    endtask

    // Build a line strip with the terminator at index ti (ti<0: none, cap length)
    task automatic build_strip(input logic [7:0] op, input int ti);
        int start, step, n;
        bit chk;
        pk.delete();
        start = op[4] ? 4 : 3;
        step  = op[4] ? 2 : 1;
        n = (ti < 0) ? 256 : ti + 1;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = $urandom;
            chk = (i >= start) && (((i - start) % step) == 0);
            if (i == 0) w[31:24] = op;
            else if (i == ti) w = (w & 32'h0FFF_0FFF) | 32'h5000_5000;
            else if (chk) w[31:28] = 4'h1;
            else if (($urandom % 3) == 0) w = (w & 32'h0FFF_0FFF) | 32'h5000_5000; // decoy
            pk.push_back(w);
        end
    endtask

    task automatic build_fixed(input logic [7:0] op);
        logic [31:0] w;
        pk.delete();
        w = $urandom;
        w[31:24] = op;
        pk.push_back(w);
        for (int i = 0; i < exp_args(op); i++) pk.push_back($urandom);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) sh[i] = {8'(8'hE0 + i), 24'h0};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        total++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0 || status !== 13'h0) begin
            bad++;
            $display("FAIL R1 ready=%0b valid=%0b status=%h expected 1 0 0", in_ready, out_valid, status);
        end
        for (int i = 0; i < 8; i++) begin
            total++;
            if (shadow_regs[i*32 +: 32] !== sh[i]) begin
                bad++;
                $display("FAIL R1 shadow%0d=%h expected %h", i, shadow_regs[i*32 +: 32], sh[i]);
            end
        end
        @(posedge clk); #1;

        // R2: every opcode of the fixed table once
        for (int op = 0; op < 256; op++) begin
            if (!is_line(8'(op))) begin
                build_fixed(8'(op));
                send_pk(exp_tag(8'(op)), 1'b0, "R2");
            end
        end
        drain();

        // R4: image transfer read and write headers
        build_fixed(8'hC5); send_pk(3'd7, 1'b0, "R4");
        build_fixed(8'hA3); send_pk(3'd6, 1'b0, "R4");
        build_fixed(8'hDF); send_pk(3'd7, 1'b0, "R4");
        // R5: flat strips, shortest and longer, with decoys at 1 and 2
        build_strip(8'h48, 3); pk[1] = 32'h5000_5000; pk[2] = 32'h5123_5456;
        send_pk(3'd4, 1'b0, "R5");
        build_strip(8'h4C, 9); send_pk(3'd4, 1'b0, "R5");
        // R6: shaded strips, decoy at odd index 5
        build_strip(8'h58, 8); pk[5] = 32'h5AAA_5BBB; send_pk(3'd4, 1'b0, "R6");
        build_strip(8'h5F, 4); send_pk(3'd4, 1'b0, "R6");
        // R7: no terminator closes at 256, terminator at 255 does not truncate
        build_strip(8'h4A, -1); send_pk(3'd4, 1'b1, "R7");
        build_strip(8'h49, 255); send_pk(3'd4, 1'b0, "R7");
        build_fixed(8'h02); send_pk(3'd1, 1'b0, "R7");
        // R8: shadow writes, including bits that reach status
        pk.delete(); pk.push_back(32'hE100_07FF); send_pk(3'd0, 1'b0, "R8");
        pk.delete(); pk.push_back(32'hE6AB_CD03); send_pk(3'd0, 1'b0, "R8");
        pk.delete(); pk.push_back(32'hE100_0405); send_pk(3'd0, 1'b0, "R8");
        drain();
        for (int i = 0; i < 8; i++) begin
            total++;
            if (shadow_regs[i*32 +: 32] !== sh[i]) begin
                bad++;
                $display("FAIL R8 shadow%0d=%h expected %h", i, shadow_regs[i*32 +: 32], sh[i]);
            end
        end

        // R10 R11: random mix under back-pressure
        bp_en = 1'b1;
        for (int n = 0; n < 400; n++) begin
            logic [7:0] op;
            op = 8'($urandom);
            if (is_line(op)) begin
                int k;
                k = $urandom % 6;
                build_strip(op, op[4] ? 4 + 2 * k : 3 + k);
                send_pk(3'd4, 1'b0, "R11");
            end else begin
                build_fixed(op);
                send_pk(exp_tag(op), 1'b0, "R11");
            end
        end
        drain();
        bp_en = 1'b0;
        check_status("R9");
        for (int i = 0; i < 8; i++) begin
            total++;
            if (shadow_regs[i*32 +: 32] !== sh[i]) begin
                bad++;
                $display("FAIL R8 shadow%0d=%h expected %h", i, shadow_regs[i*32 +: 32], sh[i]);
            end
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired, %0d words still expected", q.size());
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule